// File: doc/BRIEF.md
# Standalone Readout Test Sequencer

This block produces the stimulus a readout chain needs when no external timing system is present. A run command starts a readout cycle, shown on a cycle-active output that stays high for a fixed number of clocks. The command can ask for one cycle only. It can also ask for cycles that repeat, with a short low gap between them, until a later stop command. When the run command requested it, a one-clock accept pulse follows each cycle.

A separate single-shot command opens an ADC-clock window. Its width grows with the number of calls: the first four calls give 4 clocks (200 ns at the 20 MHz system clock), the next four give 8 clocks, and from the ninth call on every window is 12 clocks. A window-reset command returns the progression to the narrowest width. A 7-bit DAC code output either follows a stored static value or, when the ramp is enabled, counts up by one every 4 clocks while a sequence is running and wraps from 127 to 0.

All time values count clocks of the system clock. All outputs are registered.

Top module: `stim_seq_top`

## Requirements
- R1: A run write with start=1 and stop=0 while idle starts looping. cycle_active is high for CYCLE_CLKS (8) clocks, starting the clock after the write edge, then low for GAP_CLKS (3) clocks, and this repeats.
- R2: A run write with stop=1 made while cycles are looping lets the current cycle complete. No further cycle starts, and cycle_active stays low afterwards.
- R3: A run write with start=1 and stop=1 while idle produces exactly one cycle of CYCLE_CLKS clocks.
- R4: If the accept bit was set in the starting run write, accept_pulse is high for exactly one clock, one clock after each fall of cycle_active. Without the accept bit, accept_pulse stays low.
- R5: Each window-start write while the window is closed raises adc_window for 4 clocks on calls 1 to 4, 8 clocks on calls 5 to 8, and 12 clocks on call 9 and on every call after that.
- R6: A window-reset write makes the next window 4 clocks wide, and the progression starts again from call 1.
- R7: With the ramp enabled, dac_code rises by one every 4 clocks while a sequence is running. The first step comes 4 clocks after the start write edge, the code wraps from 127 to 0, and it holds while idle.
- R8: With the ramp disabled, dac_code shows the static value one clock after it is written or after the ramp is turned off. A static write made while the ramp is enabled leaves dac_code unchanged.
- R9: After reset, cycle_active, accept_pulse and adc_window are low and dac_code is 0.
- R10: A window-start write while adc_window is high is ignored. It does not change the open window and does not count as a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| run_wr | input | 1 | One-clock strobe: run register write |
| run_start | input | 1 | Run write field: start a sequence |
| run_stop | input | 1 | Run write field: stop after the current cycle |
| run_accept | input | 1 | Run write field: send an accept pulse after each cycle |
| win_start | input | 1 | One-clock strobe: open one ADC-clock window |
| win_reset | input | 1 | One-clock strobe: restart the width progression |
| ramp_wr | input | 1 | One-clock strobe: ramp enable write |
| ramp_en | input | 1 | Ramp enable value |
| static_wr | input | 1 | One-clock strobe: static DAC value write |
| static_val | input | DAC_W | Static DAC value |
| cycle_active | output | 1 | High during a readout cycle |
| accept_pulse | output | 1 | One-clock accept pulse after a cycle |
| adc_window | output | 1 | ADC-clock gate window |
| dac_code | output | DAC_W | DAC code, ramp or static |

## Verification
The assertions assume that each write strobe is high for a single clock. They also assume that window start and window reset never arrive in the same clock, and that GAP_CLKS is at least 2 so the accept pulse lands inside the gap. Reset is held for several clocks so that the two-cycle look-back on cycle_active only sees reset values at first. The directed tasks raise every strobe for exactly one clock at a falling edge and never combine a window start with a window reset. The task for R10 deliberately repeats a window start inside an open window, which is an allowed input.

// File: rtl/stim_pkg.sv
package stim_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_GAP  = 2'd2
  } run_state_e;
endpackage

// File: rtl/stim_run_ctrl.sv
module stim_run_ctrl
  import stim_pkg::*;
#(
  parameter int CYCLE_CLKS = 8,
  parameter int GAP_CLKS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run_wr,
  input  logic run_start,
  input  logic run_stop,
  input  logic run_accept,
  output logic busy_o,
  output logic cycle_active_o,
  output logic accept_pulse_o
);
  localparam int CMAX = (CYCLE_CLKS > GAP_CLKS) ? CYCLE_CLKS : GAP_CLKS;
  localparam int CW   = $clog2(CMAX + 1);

  run_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          stop_req_q;
  logic          acc_en_q;
  logic          active_q;
  logic          accept_q;
  logic          stop_now;

  assign stop_now = stop_req_q | (run_wr & run_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RS_IDLE;
      cnt_q      <= '0;
      stop_req_q <= 1'b0;
      acc_en_q   <= 1'b0;
      active_q   <= 1'b0;
      accept_q   <= 1'b0;
    end else begin
      accept_q <= 1'b0;
      case (state_q)
        RS_IDLE: begin
          if (run_wr && run_start) begin
            state_q    <= RS_RUN;
            cnt_q      <= '0;
            active_q   <= 1'b1;
            stop_req_q <= run_stop;
            acc_en_q   <= run_accept;
          end
        end
        RS_RUN: begin
          stop_req_q <= stop_now;
          if (cnt_q == CW'(CYCLE_CLKS - 1)) begin
            state_q  <= RS_GAP;
            cnt_q    <= '0;
            active_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RS_GAP: begin
          stop_req_q <= stop_now;
          if (cnt_q == '0 && acc_en_q) accept_q <= 1'b1;
          if (cnt_q == CW'(GAP_CLKS - 1)) begin
            cnt_q <= '0;
            if (stop_now) begin
              state_q <= RS_IDLE;
            end else begin
              state_q  <= RS_RUN;
              active_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != RS_IDLE);
  assign cycle_active_o = active_q;
  assign accept_pulse_o = accept_q;
endmodule

// File: rtl/stim_win_gen.sv
module stim_win_gen #(
  parameter int STEP_CLKS = 4,
  parameter int WIN_GROUP = 4,
  parameter int WIN_TIERS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic win_start,
  input  logic win_reset,
  output logic window_o
);
  localparam int NCALL = WIN_GROUP * WIN_TIERS;
  localparam int CALLW = $clog2(NCALL + 1);
  localparam int MAXW  = STEP_CLKS * WIN_TIERS;
  localparam int LW    = $clog2(MAXW + 1);

  logic [CALLW-1:0] calls_q;
  logic [LW-1:0]    left_q;
  logic             win_q;
  logic [LW-1:0]    width_c;

  always_comb begin
    width_c = LW'(MAXW);
    for (int t = WIN_TIERS - 1; t >= 0; t--) begin
      if (calls_q < CALLW'(WIN_GROUP * (t + 1))) width_c = LW'(STEP_CLKS * (t + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      calls_q <= '0;
      left_q  <= '0;
      win_q   <= 1'b0;
    end else begin
      if (win_q) begin
        if (left_q != '0) left_q <= left_q - 1'b1;
        else              win_q  <= 1'b0;
      end else if (win_start) begin
        win_q  <= 1'b1;
        left_q <= LW'(width_c - 1'b1);
        if (calls_q < CALLW'(NCALL)) calls_q <= calls_q + 1'b1;
      end
      if (win_reset) calls_q <= '0;
    end
  end

  assign window_o = win_q;
endmodule

// File: rtl/stim_dac_ramp.sv
module stim_dac_ramp #(
  parameter int DAC_W     = 7,
  parameter int STEP_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             ramp_wr,
  input  logic             ramp_en_d,
  input  logic             static_wr,
  input  logic [DAC_W-1:0] static_d,
  output logic             ramp_en_o,
  output logic [DAC_W-1:0] static_o,
  output logic [DAC_W-1:0] dac_o
);
  localparam int PW = $clog2(STEP_CLKS + 1);

  logic             ramp_en_q;
  logic [DAC_W-1:0] static_q;
  logic [PW-1:0]    pre_q;
  logic [DAC_W-1:0] dac_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_en_q <= 1'b0;
      static_q  <= '0;
      pre_q     <= '0;
      dac_q     <= '0;
    end else begin
      if (ramp_wr)   ramp_en_q <= ramp_en_d;
      if (static_wr) static_q  <= static_d;
      if (ramp_en_q && busy) begin
        if (pre_q == PW'(STEP_CLKS - 1)) begin
          pre_q <= '0;
          dac_q <= dac_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end else begin
        pre_q <= '0;
        if (!ramp_en_q) dac_q <= static_q;
      end
    end
  end

  assign ramp_en_o = ramp_en_q;
  assign static_o  = static_q;
  assign dac_o     = dac_q;
endmodule

// File: rtl/stim_seq_top.sv
module stim_seq_top #(
  parameter int CYCLE_CLKS = 8,
  parameter int GAP_CLKS   = 3,
  parameter int STEP_CLKS  = 4,
  parameter int WIN_GROUP  = 4,
  parameter int WIN_TIERS  = 3,
  parameter int DAC_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_wr,
  input  logic             run_start,
  input  logic             run_stop,
  input  logic             run_accept,
  input  logic             win_start,
  input  logic             win_reset,
  input  logic             ramp_wr,
  input  logic             ramp_en,
  input  logic             static_wr,
  input  logic [DAC_W-1:0] static_val,
  output logic             cycle_active,
  output logic             accept_pulse,
  output logic             adc_window,
  output logic [DAC_W-1:0] dac_code
);
  logic             busy;
  logic             ramp_en_q;
  logic [DAC_W-1:0] static_q;

  stim_run_ctrl #(
    .CYCLE_CLKS(CYCLE_CLKS),
    .GAP_CLKS  (GAP_CLKS)
  ) run_i (
    .clk           (clk),
    .rst           (rst),
    .run_wr        (run_wr),
    .run_start     (run_start),
    .run_stop      (run_stop),
    .run_accept    (run_accept),
    .busy_o        (busy),
    .cycle_active_o(cycle_active),
    .accept_pulse_o(accept_pulse)
  );

  stim_win_gen #(
    .STEP_CLKS(STEP_CLKS),
    .WIN_GROUP(WIN_GROUP),
    .WIN_TIERS(WIN_TIERS)
  ) win_i (
    .clk      (clk),
    .rst      (rst),
    .win_start(win_start),
    .win_reset(win_reset),
    .window_o (adc_window)
  );

  stim_dac_ramp #(
    .DAC_W    (DAC_W),
    .STEP_CLKS(STEP_CLKS)
  ) dac_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .ramp_wr  (ramp_wr),
    .ramp_en_d(ramp_en),
    .static_wr(static_wr),
    .static_d (static_val),
    .ramp_en_o(ramp_en_q),
    .static_o (static_q),
    .dac_o    (dac_code)
  );
endmodule

// File: rtl/stim_seq_chk.sv
module stim_seq_chk #(
  parameter int CYCLE_CLKS = 8,
  parameter int STEP_CLKS  = 4,
  parameter int WIN_TIERS  = 3,
  parameter int DAC_W      = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cycle_active,
  input logic             accept_pulse,
  input logic             adc_window,
  input logic [DAC_W-1:0] dac_code,
  input logic             busy,
  input logic             ramp_en_q,
  input logic [DAC_W-1:0] static_q
);
  localparam int MAXW = STEP_CLKS * WIN_TIERS;

  logic [15:0] act_len;
  logic [15:0] win_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_len <= '0;
      win_len <= '0;
    end else begin
      act_len <= cycle_active ? act_len + 1'b1 : '0;
      win_len <= adc_window   ? win_len + 1'b1 : '0;
    end
  end

  // R1: a cycle never lasts longer than CYCLE_CLKS
  p_cycle_len_r1: assert property (@(posedge clk) disable iff (rst)
    cycle_active |-> (act_len < 16'(CYCLE_CLKS)));

  // R4: accept comes one clock after the fall of cycle_active
  p_accept_after_fall_r4: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |-> (!$past(cycle_active) && $past(cycle_active, 2)));

  // R4: accept is one clock wide
  p_accept_single_r4: assert property (@(posedge clk) disable iff (rst)
    accept_pulse |=> !accept_pulse);

  // R5: a window is never wider than the top tier
  p_win_max_r5: assert property (@(posedge clk) disable iff (rst)
    adc_window |-> (win_len < 16'(MAXW)));

  // R7: while the ramp is on, the code holds or steps up by one
  p_ramp_step_r7: assert property (@(posedge clk) disable iff (rst)
    (ramp_en_q && $past(ramp_en_q)) |->
      (dac_code == $past(dac_code) || dac_code == DAC_W'($past(dac_code) + 1'b1)));

  // R7: the ramp holds while idle
  p_ramp_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $past(ramp_en_q && !busy) |-> $stable(dac_code));

  // R8: with the ramp off, the code follows the stored static value
  p_static_follow_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!ramp_en_q) |-> (dac_code == $past(static_q)));
endmodule

bind stim_seq_top stim_seq_chk #(
  .CYCLE_CLKS(CYCLE_CLKS),
  .STEP_CLKS (STEP_CLKS),
  .WIN_TIERS (WIN_TIERS),
  .DAC_W     (DAC_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cycle_active(cycle_active),
  .accept_pulse(accept_pulse),
  .adc_window  (adc_window),
  .dac_code    (dac_code),
  .busy        (busy),
  .ramp_en_q   (ramp_en_q),
  .static_q    (static_q)
);

// File: tb/stim_seq_top_tb.sv
module stim_seq_top_tb_top;
  localparam int C = 8;
  localparam int G = 3;
  localparam int P = C + G;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_wr = 0, run_start = 0, run_stop = 0, run_accept = 0;
  logic       win_start = 0, win_reset = 0;
  logic       ramp_wr = 0, ramp_en = 0, static_wr = 0;
  logic [6:0] static_val = '0;
  logic       cycle_active, accept_pulse, adc_window;
  logic [6:0] dac_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stim_seq_top dut_i (
    .clk(clk), .rst(rst),
    .run_wr(run_wr), .run_start(run_start), .run_stop(run_stop), .run_accept(run_accept),
    .win_start(win_start), .win_reset(win_reset),
    .ramp_wr(ramp_wr), .ramp_en(ramp_en), .static_wr(static_wr), .static_val(static_val),
    .cycle_active(cycle_active), .accept_pulse(accept_pulse),
    .adc_window(adc_window), .dac_code(dac_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic run_pulse(input bit s, input bit p, input bit a);
    run_start = s; run_stop = p; run_accept = a; run_wr = 1;
    step();
    run_wr = 0; run_start = 0; run_stop = 0; run_accept = 0;
  endtask

  task automatic win_pulse(); win_start = 1; step(); win_start = 0; endtask
  task automatic wrst_pulse(); win_reset = 1; step(); win_reset = 0; endtask
  task automatic ramp_pulse(input bit e); ramp_en = e; ramp_wr = 1; step(); ramp_wr = 0; endtask
  task automatic static_pulse(input int v);
    static_val = 7'(v); static_wr = 1; step(); static_wr = 0;
  endtask

  task automatic t_reset_r9();
    chk(cycle_active == 0, "R9 cycle_active", cycle_active, 0);
    chk(accept_pulse == 0, "R9 accept_pulse", accept_pulse, 0);
    chk(adc_window == 0, "R9 adc_window", adc_window, 0);
    chk(dac_code == 0, "R9 dac_code", dac_code, 0);
  endtask

  task automatic t_loop_stop_r1_r2();
    run_pulse(1, 0, 0);
    for (int k = 0; k < 2 * P; k++) begin
      chk(cycle_active == ((k % P) < C), "R1 loop pattern", cycle_active, (k % P) < C);
      chk(accept_pulse == 0, "R4 no accept without bit", accept_pulse, 0);
      step();
    end
    run_pulse(0, 1, 0);
    for (int k = 2 * P + 1; k <= 4 * P; k++) begin
      chk(cycle_active == (k < 2 * P + C), "R2 stop after current cycle", cycle_active, k < 2 * P + C);
      step();
    end
  endtask

  task automatic t_single_accept_r3_r4();
    run_pulse(1, 1, 1);
    for (int k = 0; k <= 2 * P; k++) begin
      chk(cycle_active == (k < C), "R3 single cycle", cycle_active, k < C);
      chk(accept_pulse == (k == C + 1), "R4 accept timing", accept_pulse, k == C + 1);
      step();
    end
  endtask

  task automatic t_ramp_r7_r8();
    int held;
    static_pulse(125);
    step();
    chk(dac_code == 125, "R8 static applied", dac_code, 125);
    ramp_pulse(1);
    repeat (3) step();
    chk(dac_code == 125, "R7 idle hold after enable", dac_code, 125);
    static_pulse(10);
    repeat (2) step();
    chk(dac_code == 125, "R8 static ignored while ramp on", dac_code, 125);
    run_pulse(1, 0, 0);
    for (int k = 0; k < 16; k++) begin
      chk(dac_code == (125 + k / 4) % 128, "R7 ramp step and wrap", dac_code, (125 + k / 4) % 128);
      step();
    end
    run_pulse(0, 1, 0);
    repeat (2 * P) step();
    chk(cycle_active == 0, "R2 idle after stop", cycle_active, 0);
    held = dac_code;
    repeat (6) step();
    chk(dac_code == held, "R7 hold while idle", dac_code, held);
    ramp_pulse(0);
    step();
    chk(dac_code == 10, "R8 static after ramp off", dac_code, 10);
  endtask

  task automatic win_call(input int exp, input string tag);
    int n = 0;
    win_pulse();
    while (adc_window && n < 40) begin n++; step(); end
    chk(n == exp, tag, n, exp);
    step();
  endtask

  task automatic t_window_r5_r6_r10();
    int n = 0;
    for (int c = 1; c <= 13; c++)
      win_call((c <= 4) ? 4 : ((c <= 8) ? 8 : 12), "R5 window width");
    wrst_pulse();
    step();
    win_pulse();
    step();
    win_pulse();
    while (adc_window && n < 40) begin n++; step(); end
    chk(n == 2, "R10 open window unchanged", n, 2);
    chk(adc_window == 0, "R6 first width after reset", adc_window, 0);
    step();
    for (int c = 2; c <= 4; c++) win_call(4, "R10 ignored call not counted");
    win_call(8, "R6 progression restarted");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    step();
    t_reset_r9();
    t_loop_stop_r1_r2();
    t_single_accept_r3_r4();
    t_ramp_r7_r8();
    t_window_r5_r6_r10();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule